// File: doc/BRIEF.md
# Serial Receiver Status and Interrupt Flags

This block sits beside a UART-style receive shift register and holds the software-facing state of the receiver. When the shift register reports a finished byte, the block loads it into a holding data register and raises a receive-data-full flag. If a further byte finishes while the held byte is still unread, the new byte is dropped, the held byte is kept, and an overrun flag is raised.

The block also watches the serial line, sampled once per bit time. It counts consecutive high samples, and when the run covers a whole character time it raises an idle-line flag. A whole character time is 10 bit times for 8-bit frames and 11 for 9-bit frames. After the idle flag fires once it stays quiet until another byte has been received. Software clears all three flags by reading the status register and then reading the data register. A registered interrupt request is formed from the flags, the per-source enables and a global mask.

Top module: `uart_rx_status`

## Requirements
- R1: When `byte_done` is high and `rdf` is low, the clock edge loads `byte_in` into `rx_data` and sets `rdf`. Both are visible after that edge.
- R2: When `byte_done` is high while `rdf` is high, and there is no clearing read (R3) in that cycle, `ovr` sets at that edge. In the same case `rx_data` keeps its earlier value and `rdf` stays high.
- R3: A `stat_rd` arms the clear. The first later cycle with `data_rd` while armed is a clearing read: at that edge it clears `rdf`, `ovr` and `idle`, and it uses up the arm. A `data_rd` with no arm, or a `stat_rd` alone, changes no flag. If `byte_done` comes in the same cycle as a clearing read, the new byte loads, `rdf` stays high and `ovr` clears.
- R4: On each cycle with `smp_valid` high, a high `line_smp` extends the run of ones and a low `line_smp` resets the run to zero. The run saturates at 11. Cycles with `smp_valid` low leave the run unchanged. `idle` sets at the edge of a valid high sample that brings the run to at least the threshold, which is 10 when `nine_bit` is 0 and 11 when `nine_bit` is 1. This happens only while idle detection is armed. A set and a clearing read in the same cycle leave `idle` high.
- R5: Setting `idle` disarms idle detection, and a `byte_done` re-arms it. `byte_done` wins if both happen in one cycle. Detection starts armed after reset. Once the run has reached the threshold, the next valid high sample after a re-arm sets `idle`.
- R6: `irq` is registered. After each edge it equals `!irq_mask && ((rx_ie && (rdf || ovr)) || (idle_ie && idle))`, evaluated with the flag and input values that held before that edge.
- R7: A synchronous reset clears `rx_data`, `rdf`, `ovr`, `idle`, `irq`, the run of ones and the clear arm, and it arms idle detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_done | input | 1 | Strobe: a byte finished shifting in |
| byte_in | input | DATA_W | Byte from the shift register |
| stat_rd | input | 1 | Strobe: software read of the status register |
| data_rd | input | 1 | Strobe: software read of the data register |
| smp_valid | input | 1 | Bit-time strobe for `line_smp` |
| line_smp | input | 1 | Sampled receive line |
| nine_bit | input | 1 | 1 selects the 11-bit idle threshold, 0 selects 10 |
| rx_ie | input | 1 | Enables data-full and overrun interrupts |
| idle_ie | input | 1 | Enables the idle-line interrupt |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks `irq` |
| rx_data | output | DATA_W | Held received byte |
| rdf | output | 1 | Receive data register full |
| ovr | output | 1 | Overrun flag |
| idle | output | 1 | Idle-line flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench sends a second byte into an unread register. A design that overwrote the held byte, or dropped `rdf`, would show the wrong data or lose the flag. It issues a data read with no status read in front of it, which a design without sequence tracking would take as a clear. It also lands a byte in the same cycle as a clearing read, where a naive design would flag a false overrun. For the idle logic it stops one sample short of the 10 and 11 thresholds and interleaves invalid sample cycles, so off-by-one counters and counters that run on every clock are exposed. Holding the line high after a clear exposes a design that fires the idle flag again without a byte in between.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;
  typedef struct packed {
    logic rdf;
    logic ovr;
    logic idle;
  } rx_flags_t;
endpackage

// File: rtl/rx_clear_seq.sv
module rx_clear_seq (
  input  logic clk,
  input  logic rst,
  input  logic stat_rd,
  input  logic data_rd,
  output logic clr
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst)          armed_q <= 1'b0;
    else if (stat_rd) armed_q <= 1'b1;
    else if (data_rd) armed_q <= 1'b0;
  end

  assign clr = data_rd & armed_q;

  // a data read with no status read beside it uses up the arm
  assert_arm_consumed_R3: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !stat_rd) |=> !armed_q);
endmodule

// File: rtl/rx_data_hold.sv
module rx_data_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              clr,
  output logic [DATA_W-1:0] data_q,
  output logic              rdf_q,
  output logic              ovr_q
);
  logic lose_byte;
  assign lose_byte = byte_done & rdf_q & ~clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      rdf_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (lose_byte) begin
      ovr_q <= 1'b1;
    end else if (byte_done) begin
      data_q <= byte_in;
      rdf_q  <= 1'b1;
      if (clr) ovr_q <= 1'b0;
    end else if (clr) begin
      rdf_q <= 1'b0;
      ovr_q <= 1'b0;
    end
  end

  assert_load_R1: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !rdf_q) |=> (rdf_q && data_q == $past(byte_in)));

  assert_overrun_keeps_R2: assert property (@(posedge clk) disable iff (rst)
    (byte_done && rdf_q && !clr) |=> (ovr_q && rdf_q && data_q == $past(data_q)));
endmodule

// File: rtl/rx_idle_detect.sv
module rx_idle_detect #(
  parameter int RUN_8 = 10,
  parameter int RUN_9 = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_valid,
  input  logic line_smp,
  input  logic nine_bit,
  input  logic byte_done,
  input  logic clr,
  output logic idle_q
);
  localparam int CNT_W = $clog2(RUN_9 + 1);
  localparam logic [CNT_W-1:0] THR8 = CNT_W'(RUN_8);
  localparam logic [CNT_W-1:0] THR9 = CNT_W'(RUN_9);

  logic [CNT_W-1:0] run_q, run_n, thr;
  logic             armed_q, idle_set;

  assign thr = nine_bit ? THR9 : THR8;

  always_comb begin
    run_n = run_q;
    if (smp_valid) begin
      if (!line_smp)          run_n = '0;
      else if (run_q < THR9)  run_n = run_q + 1'b1;
    end
  end

  assign idle_set = smp_valid & line_smp & armed_q & (run_n >= thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      armed_q <= 1'b1;
      idle_q  <= 1'b0;
    end else begin
      run_q <= run_n;
      if (byte_done)     armed_q <= 1'b1;
      else if (idle_set) armed_q <= 1'b0;
      if (idle_set)      idle_q <= 1'b1;
      else if (clr)      idle_q <= 1'b0;
    end
  end

  assert_idle_on_high_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_q) |-> $past(smp_valid && line_smp));

  assert_zero_resets_run_R4: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !line_smp) |=> !$rose(idle_q));

  assert_disarm_R5: assert property (@(posedge clk) disable iff (rst)
    (idle_set && !byte_done) |=> !armed_q);
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen
  import uart_rx_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  rx_flags_t flags,
  input  logic      rx_ie,
  input  logic      idle_ie,
  input  logic      irq_mask,
  output logic      irq_q
);
  logic req;
  assign req = (rx_ie & (flags.rdf | flags.ovr)) | (idle_ie & flags.idle);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= req & ~irq_mask;
  end

  assert_irq_masked_R6: assert property (@(posedge clk) disable iff (rst)
    irq_mask |=> !irq_q);

  assert_irq_has_source_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(flags.rdf || flags.ovr || flags.idle));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RUN_8  = 10,
  parameter int RUN_9  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              smp_valid,
  input  logic              line_smp,
  input  logic              nine_bit,
  input  logic              rx_ie,
  input  logic              idle_ie,
  input  logic              irq_mask,
  output logic [DATA_W-1:0] rx_data,
  output logic              rdf,
  output logic              ovr,
  output logic              idle,
  output logic              irq
);
  logic      clr;
  rx_flags_t flags;

  rx_clear_seq u_clr (
    .clk(clk), .rst(rst), .stat_rd(stat_rd), .data_rd(data_rd), .clr(clr)
  );

  rx_data_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .byte_done(byte_done), .byte_in(byte_in),
    .clr(clr), .data_q(rx_data), .rdf_q(rdf), .ovr_q(ovr)
  );

  rx_idle_detect #(.RUN_8(RUN_8), .RUN_9(RUN_9)) u_idle (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .line_smp(line_smp),
    .nine_bit(nine_bit), .byte_done(byte_done), .clr(clr), .idle_q(idle)
  );

  assign flags = '{rdf: rdf, ovr: ovr, idle: idle};

  rx_irq_gen u_irq (
    .clk(clk), .rst(rst), .flags(flags), .rx_ie(rx_ie), .idle_ie(idle_ie),
    .irq_mask(irq_mask), .irq_q(irq)
  );

  // overrun only drops on a data register read
  assert_ovr_clear_by_read_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ovr) |-> $past(data_rd));
endmodule

// File: tb/uart_rx_status_tb.sv
module uart_rx_status_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic byte_done = 0, stat_rd = 0, data_rd = 0, smp_valid = 0, line_smp = 1;
  logic [7:0] byte_in = '0;
  logic nine_bit = 0, rx_ie = 0, idle_ie = 0, irq_mask = 1;
  logic [7:0] rx_data;
  logic rdf, ovr, idle, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_data;
  logic m_rdf, m_ovr, m_idle, m_irq, m_arm, m_iarm;
  int m_run;

  always #10 clk = ~clk;

  uart_rx_status u_dut (
    .clk(clk), .rst(rst), .byte_done(byte_done), .byte_in(byte_in),
    .stat_rd(stat_rd), .data_rd(data_rd), .smp_valid(smp_valid),
    .line_smp(line_smp), .nine_bit(nine_bit), .rx_ie(rx_ie),
    .idle_ie(idle_ie), .irq_mask(irq_mask), .rx_data(rx_data), .rdf(rdf),
    .ovr(ovr), .idle(idle), .irq(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int thr_of(logic nb);
    return nb ? 11 : 10;
  endfunction

  task automatic model_reset();
    m_data = '0; m_rdf = 0; m_ovr = 0; m_idle = 0; m_irq = 0;
    m_arm = 0; m_iarm = 1; m_run = 0;
  endtask

  task automatic model_step();
    logic clr, iset;
    clr = data_rd && m_arm;
    m_irq = !irq_mask && ((rx_ie && (m_rdf || m_ovr)) || (idle_ie && m_idle));
    if (byte_done && m_rdf && !clr) m_ovr = 1;
    else if (byte_done) begin
      m_data = byte_in; m_rdf = 1;
      if (clr) m_ovr = 0;
    end else if (clr) begin
      m_rdf = 0; m_ovr = 0;
    end
    if (smp_valid) m_run = !line_smp ? 0 : (m_run < 11 ? m_run + 1 : m_run);
    iset = smp_valid && line_smp && m_iarm && (m_run >= thr_of(nine_bit));
    if (iset) m_idle = 1; else if (clr) m_idle = 0;
    if (byte_done) m_iarm = 1; else if (iset) m_iarm = 0;
    m_arm = stat_rd ? 1'b1 : (data_rd ? 1'b0 : m_arm);
  endtask

  task automatic compare_all();
    chk("R1/R2", "rx_data", rx_data, m_data);
    chk("R1/R3", "rdf", rdf, m_rdf);
    chk("R2/R3", "ovr", ovr, m_ovr);
    chk("R4/R5", "idle", idle, m_idle);
    chk("R6", "irq", irq, m_irq);
  endtask

  // drive one cycle of strobes; inputs change at the falling edge
  task automatic cyc(bit bd = 0, logic [7:0] b = 8'h00, bit sr = 0, bit dr = 0,
                     bit sv = 0, bit ln = 1);
    byte_done = bd; byte_in = b; stat_rd = sr; data_rd = dr;
    smp_valid = sv; line_smp = ln;
    model_step();
    @(posedge clk);
    @(negedge clk);
    byte_done = 0; stat_rd = 0; data_rd = 0; smp_valid = 0;
    compare_all();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R7: reset state
    chk("R7", "rx_data", rx_data, 0); chk("R7", "rdf", rdf, 0);
    chk("R7", "ovr", ovr, 0); chk("R7", "idle", idle, 0); chk("R7", "irq", irq, 0);

    cyc(1, 8'hA5);
    chk("R1", "load data", rx_data, 8'hA5); chk("R1", "rdf set", rdf, 1);
    cyc(1, 8'h3C);
    chk("R2", "ovr set", ovr, 1); chk("R2", "data kept", rx_data, 8'hA5);
    cyc(0, 0, 0, 1);
    chk("R3", "data read without status read keeps ovr", ovr, 1);
    cyc(0, 0, 1, 0);
    chk("R3", "status read alone keeps ovr", ovr, 1);
    cyc(0, 0, 0, 1);
    chk("R3", "sequence clears ovr", ovr, 0); chk("R3", "sequence clears rdf", rdf, 0);

    // R4: 8-bit threshold, invalid cycles in between are ignored
    cyc(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 9; i++) begin
      cyc(0, 0, 0, 0, 1, 1);
      cyc(0, 0, 0, 0, 0, 0);
    end
    chk("R4", "idle after 9 ones", idle, 0);
    cyc(0, 0, 0, 0, 1, 1);
    chk("R4", "idle after 10 ones", idle, 1);

    // R5: no second idle without a byte
    cyc(0, 0, 1, 0); cyc(0, 0, 0, 1);
    chk("R3", "sequence clears idle", idle, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 1);
    chk("R5", "idle stays clear without a byte", idle, 0);
    cyc(1, 8'h5A);
    cyc(0, 0, 0, 0, 1, 1);
    chk("R5", "idle after re-arm", idle, 1);

    // R4: 9-bit threshold
    cyc(0, 0, 1, 0); cyc(0, 0, 0, 1);
    nine_bit = 1;
    cyc(0, 0, 0, 0, 1, 0);
    cyc(1, 8'h77);
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0, 1, 1);
    chk("R4", "idle after 10 ones, 9-bit frame", idle, 0);
    cyc(0, 0, 0, 0, 1, 1);
    chk("R4", "idle after 11 ones, 9-bit frame", idle, 1);

    // R6: interrupt gating
    rx_ie = 1; irq_mask = 0; cyc();
    chk("R6", "irq from rdf", irq, 1);
    irq_mask = 1; cyc();
    chk("R6", "irq masked", irq, 0);
    irq_mask = 0; rx_ie = 0; cyc();
    chk("R6", "irq with sources disabled", irq, 0);
    idle_ie = 1; cyc();
    chk("R6", "irq from idle", irq, 1);

    // R2/R3: byte lands in the same cycle as a clearing read
    cyc(1, 8'h11);
    chk("R2", "ovr before clearing read", ovr, 1);
    cyc(0, 0, 1, 0);
    cyc(1, 8'hE1, 0, 1);
    chk("R3", "byte with clearing read loads", rx_data, 8'hE1);
    chk("R3", "rdf stays with new byte", rdf, 1);
    chk("R3", "ovr cleared", ovr, 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit bd, sr, dr, sv, ln;
      bd = ($urandom % 8) == 0;
      sr = ($urandom % 6) == 0;
      dr = ($urandom % 6) == 0;
      sv = ($urandom % 3) != 0;
      ln = ($urandom % 14) != 0;
      if (($urandom % 50) == 0) nine_bit = $urandom % 2;
      if (($urandom % 40) == 0) begin
        rx_ie = $urandom % 2; idle_ie = $urandom % 2; irq_mask = ($urandom % 4) == 0;
      end
      cyc(bd, 8'($urandom), sr, dr, sv, ln);
    end

    // R7: reset mid-run
    rst = 1; @(posedge clk); @(negedge clk); rst = 0;
    model_reset();
    chk("R7", "rdf after reset", rdf, 0); chk("R7", "idle after reset", idle, 0);
    chk("R7", "irq after reset", irq, 0); chk("R7", "data after reset", rx_data, 0);

    done = 1;
    finish_run();
  end
endmodule